// File: doc/BRIEF.md
# Auxiliary NMI Latch Controller

This block adds two auxiliary non-maskable interrupt sources, a system-fail line and an abort pushbutton, to a PC-style NMI path. Each source goes through a two-flop synchronizer. It then drives a small per-source state machine. That machine arms when both a global auxiliary enable and the source's own enable are set. When the synchronized event is seen while the machine is armed, the machine latches and stays latched.

Software talks to the block over a byte-wide I/O-mapped port. That port holds the legacy NMI mask bit, the global auxiliary enable, a routing select and the per-source enables. A status byte shows which latch is set. The single NMI output is raised when three things hold together: a latch is set, the routing select steers the latches onto the NMI, and the legacy mask allows delivery.

Each source state machine has three states:
- `SRC_OFF`: disarmed.
- `SRC_ARMED`: enabled and waiting for an event.
- `SRC_FIRED`: latched.

The transitions are:
- **arm**: `SRC_OFF` to `SRC_ARMED`, when both enables are set.
- **fire**: `SRC_OFF` or `SRC_ARMED` to `SRC_FIRED`, when both enables are set and the event is active in the same cycle.
- **disarm**: any state to `SRC_OFF`, when either enable is clear.
- **hold**: `SRC_FIRED` stays in `SRC_FIRED` while both enables stay set.

Top module: `aux_nmi_ctrl`

## Requirements
- R1: After reset, and again after a reset in mid-operation, the following hold. The legacy mask disables delivery. The global enable, the routing select and both source enables are 0. Both latches are clear. `nmi_out` is 0 and the status byte reads 0x00.
- R2: A write to address 0x0070 loads the legacy mask from data bit 7: 1 blocks delivery and 0 allows it. While delivery is blocked, `nmi_out` stays 0 even with a latch set.
- R3: When the global enable and a source's own enable are both set and the active-low event input is held low, that source's latch sets. The status byte at address 0x0032 shows the system-fail latch in bit 2 and the abort latch in bit 3.
- R4: An event is ignored while the global enable (data bit 4 of a write to address 0x0036) is 0, or while the source's own enable is 0. The own enables are written at address 0x003E: bit 2 for system-fail and bit 3 for abort.
- R5: A set latch stays set after its event input returns high, as long as both of its enables stay set.
- R6: Writing 0 to the global enable clears both latches. Clearing one source's own enable clears only that source's latch. Re-enabling does not set a latch again without a new event.
- R7: `nmi_out` is 1 when at least one latch is set, the routing select is 0 and the mask allows delivery. It follows these conditions one clock later.
- R8: A routing select of 1, written as data bit 0 at address 0x0038, holds `nmi_out` at 0 while the latches keep their state.
- R9: The two sources latch independently. An event on one source does not set the other source's latch.
- R10: Writes to any other address change nothing. Reads from any address other than 0x0032 return 0x00, and status bits 7..4 and 1..0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| sysfail_n | input | 1 | Active-low system-fail event, asynchronous |
| abort_n | input | 1 | Active-low abort pushbutton event, asynchronous |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
The bench fires events with no enable set, with only the source's own enable set, and with only the global enable set. These patterns show that both enable levels are needed to arm a source. It then fires each source alone and then both sources together, which shows that the sources are independent and that each maps to its own status bit.

The three NMI gating conditions are toggled one at a time while a latch is held:
- the legacy mask;
- the routing select;
- the global enable.

This separates blocking the output, which keeps the latch, from disarming, which clears it. A reset in mid-operation shows that the mask returns to its blocking value.

// File: rtl/aux_nmi_pkg.sv
package aux_nmi_pkg;
    localparam int NSRC      = 2;   // 0: system-fail, 1: abort
    localparam int EN_BIT0   = 2;   // first per-source enable bit
    localparam int STAT_BIT0 = 2;   // first per-source status bit
    localparam int GLOB_BIT  = 4;
    localparam int ROUTE_BIT = 0;
    localparam int MASK_BIT  = 7;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_ARMED = 2'd1,
        SRC_FIRED = 2'd2
    } src_state_t;
endpackage

// File: rtl/aux_nmi_sync.sv
module aux_nmi_sync #(
    parameter int WIDTH     = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= {WIDTH{RESET_VAL}};
            sync_out <= {WIDTH{RESET_VAL}};
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/aux_nmi_regs.sv
module aux_nmi_regs
    import aux_nmi_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] MASK_ADDR  = 16'h0070,
    parameter logic [ADDR_W-1:0] GLOB_ADDR  = 16'h0036,
    parameter logic [ADDR_W-1:0] ROUTE_ADDR = 16'h0038,
    parameter logic [ADDR_W-1:0] EN_ADDR    = 16'h003E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic              mask_dis,
    output logic              glob_en,
    output logic              route_sel,
    output logic [NSRC-1:0]   src_en
);
    logic unused_wdata_bits;
    assign unused_wdata_bits = ^io_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_dis  <= 1'b1;
            glob_en   <= 1'b0;
            route_sel <= 1'b0;
            src_en    <= '0;
        end else if (io_wr) begin
            if (io_addr == MASK_ADDR)  mask_dis  <= io_wdata[MASK_BIT];
            if (io_addr == GLOB_ADDR)  glob_en   <= io_wdata[GLOB_BIT];
            if (io_addr == ROUTE_ADDR) route_sel <= io_wdata[ROUTE_BIT];
            if (io_addr == EN_ADDR)    src_en    <= io_wdata[EN_BIT0 +: NSRC];
        end
    end
endmodule

// File: rtl/aux_nmi_src_fsm.sv
module aux_nmi_src_fsm
    import aux_nmi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic event_on,
    output logic fired
);
    src_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SRC_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SRC_OFF: begin
                if (armed && event_on) state_nx = SRC_FIRED;   // fire
                else if (armed)        state_nx = SRC_ARMED;   // arm
            end
            SRC_ARMED: begin
                if (!armed)        state_nx = SRC_OFF;         // disarm
                else if (event_on) state_nx = SRC_FIRED;       // fire
            end
            SRC_FIRED: begin
                if (!armed) state_nx = SRC_OFF;                // disarm
            end
            default: state_nx = SRC_OFF;
        endcase
    end

    always_comb begin
        fired = (state == SRC_FIRED);
    end
endmodule

// File: rtl/aux_nmi_ctrl.sv
module aux_nmi_ctrl
    import aux_nmi_pkg::*;
#(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] MASK_ADDR  = 16'h0070,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 16'h0032,
    parameter logic [ADDR_W-1:0] GLOB_ADDR  = 16'h0036,
    parameter logic [ADDR_W-1:0] ROUTE_ADDR = 16'h0038,
    parameter logic [ADDR_W-1:0] EN_ADDR    = 16'h003E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              sysfail_n,
    input  logic              abort_n,
    output logic              nmi_out
);
    logic            mask_dis;
    logic            glob_en;
    logic            route_sel;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] evt_n_sync;
    logic [NSRC-1:0] fired;

    aux_nmi_regs #(
        .ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR), .GLOB_ADDR(GLOB_ADDR),
        .ROUTE_ADDR(ROUTE_ADDR), .EN_ADDR(EN_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .mask_dis(mask_dis), .glob_en(glob_en),
        .route_sel(route_sel), .src_en(src_en)
    );

    aux_nmi_sync #(.WIDTH(NSRC), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({abort_n, sysfail_n}),
        .sync_out(evt_n_sync)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        aux_nmi_src_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .armed(glob_en && src_en[i]),
            .event_on(!evt_n_sync[i]),
            .fired(fired[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) nmi_out <= 1'b0;
        else        nmi_out <= (|fired) && !route_sel && !mask_dis;
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd && io_addr == STAT_ADDR)
            io_rdata[STAT_BIT0 +: NSRC] = fired;
    end
endmodule

// File: rtl/aux_nmi_checker.sv
module aux_nmi_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mask_dis,
    input logic       glob_en,
    input logic       route_sel,
    input logic [1:0] src_en,
    input logic [1:0] fired,
    input logic       nmi_out,
    input logic [7:0] io_rdata
);
    a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mask_dis |=> !nmi_out);

    a_r8_route_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        route_sel |=> !nmi_out);

    a_r6_glob_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> (fired == 2'b00));

    a_r4_own_enable_sysfail: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en[0] |=> !fired[0]);

    a_r4_own_enable_abort: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en[1] |=> !fired[1]);

    a_r5_sticky_sysfail: assert property (@(posedge clk) disable iff (!rst_n)
        (fired[0] && glob_en && src_en[0]) |=> fired[0]);

    a_r5_sticky_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (fired[1] && glob_en && src_en[1]) |=> fired[1]);

    a_r10_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rdata[7:4] == 4'h0) && (io_rdata[1:0] == 2'b00));
endmodule

bind aux_nmi_ctrl aux_nmi_checker u_chk (
    .clk(clk), .rst_n(rst_n), .mask_dis(mask_dis), .glob_en(glob_en),
    .route_sel(route_sel), .src_en(src_en), .fired(fired),
    .nmi_out(nmi_out), .io_rdata(io_rdata)
);

// File: tb/aux_nmi_ctrl_test.sv
`timescale 1ns/1ps
module aux_nmi_ctrl_test;
    localparam int HALF = 4;   // 125 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        sysfail_n = 1'b1;
    logic        abort_n = 1'b1;
    logic        nmi_out;
    logic        smp_nmi = 1'b0;
    bit          done = 1'b0;

    int vectors = 0;
    int fails = 0;

    typedef struct {
        bit       is_nmi;
        logic [7:0] exp;
        string    req;
    } item_t;
    item_t sb[$];

    always #HALF clk = ~clk;

    aux_nmi_ctrl uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .sysfail_n(sysfail_n), .abort_n(abort_n), .nmi_out(nmi_out)
    );

    // monitor: compares at the falling edge
    always @(negedge clk) begin
        if (io_rd || smp_nmi) begin
            logic [7:0] act;
            item_t it;
            vectors++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: act rdata=%02h nmi=%0b exp=<item>", io_rdata, nmi_out);
            end else begin
                it = sb.pop_front();
                act = it.is_nmi ? {7'b0, nmi_out} : io_rdata;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: %s act=%02h exp=%02h", it.req,
                             it.is_nmi ? "nmi_out" : "rdata", act, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
        idle(2);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string req);
        item_t it;
        it.is_nmi = 1'b0; it.exp = e; it.req = req;
        @(posedge clk); #1;
        sb.push_back(it);
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic chk_nmi(input logic e, input string req);
        item_t it;
        it.is_nmi = 1'b1; it.exp = {7'b0, e}; it.req = req;
        @(posedge clk); #1;
        sb.push_back(it);
        smp_nmi = 1'b1;
        @(posedge clk); #1;
        smp_nmi = 1'b0;
    endtask

    task automatic pulse_evt(input bit which_abort);
        if (which_abort) abort_n = 1'b0; else sysfail_n = 1'b0;
        idle(5);
        if (which_abort) abort_n = 1'b1; else sysfail_n = 1'b1;
        idle(5);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(2 * HALF * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: act=timeout exp=finish");
            summary();
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd(16'h0032, 8'h00, "R1 status after reset");
        chk_nmi(1'b0, "R1 nmi after reset");

        // R4 no enables, own only, global only
        pulse_evt(1'b0);
        rd(16'h0032, 8'h00, "R4 no enables");
        wr(16'h003E, 8'h04);
        pulse_evt(1'b0);
        rd(16'h0032, 8'h00, "R4 own enable only");
        wr(16'h0036, 8'h10);
        pulse_evt(1'b1);
        rd(16'h0032, 8'h00, "R4 abort own enable off");

        // R3 / R5 sysfail latch, R2 mask still blocking
        sysfail_n = 1'b0; idle(5);
        rd(16'h0032, 8'h04, "R3 sysfail latched bit2");
        chk_nmi(1'b0, "R2 mask blocks from reset");
        sysfail_n = 1'b1; idle(5);
        rd(16'h0032, 8'h04, "R5 sticky after release");

        // R7 / R8 / R2 gating
        wr(16'h0070, 8'h00);
        chk_nmi(1'b1, "R7 nmi asserted");
        wr(16'h0038, 8'h01);
        chk_nmi(1'b0, "R8 route blocks");
        rd(16'h0032, 8'h04, "R8 latch kept while unrouted");
        wr(16'h0038, 8'h00);
        chk_nmi(1'b1, "R7 nmi after reroute");
        wr(16'h0070, 8'h80);
        chk_nmi(1'b0, "R2 mask bit7 blocks");
        wr(16'h0070, 8'h00);
        chk_nmi(1'b1, "R2 mask bit7 clear allows");

        // R9 both sources
        wr(16'h003E, 8'h0C);
        pulse_evt(1'b1);
        rd(16'h0032, 8'h0C, "R9 both latched");
        // R6 individual clear
        wr(16'h003E, 8'h08);
        rd(16'h0032, 8'h08, "R6 own enable clears sysfail only");
        chk_nmi(1'b1, "R7 abort alone drives nmi");

        // R10 other addresses
        wr(16'h0055, 8'h00);
        wr(16'h0037, 8'h00);
        rd(16'h0032, 8'h08, "R10 stray writes ignored");
        rd(16'h0070, 8'h00, "R10 read elsewhere zero");

        // R6 global clear, no re-latch
        wr(16'h0036, 8'h00);
        rd(16'h0032, 8'h00, "R6 global clear");
        chk_nmi(1'b0, "R7 nmi drops with latches");
        wr(16'h0036, 8'h10);
        rd(16'h0032, 8'h00, "R6 no re-latch without event");

        // R9 abort alone does not touch sysfail
        wr(16'h003E, 8'h0C);
        pulse_evt(1'b1);
        rd(16'h0032, 8'h08, "R9 abort only");

        // R1 mid-run reset
        @(posedge clk); #1;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        rd(16'h0032, 8'h00, "R1 status after mid reset");
        chk_nmi(1'b0, "R1 nmi after mid reset");
        wr(16'h0036, 8'h10);
        wr(16'h003E, 8'h04);
        pulse_evt(1'b0);
        rd(16'h0032, 8'h04, "R3 sysfail after mid reset");
        chk_nmi(1'b0, "R1 mask disabled again after reset");

        idle(3);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard leftover: act=%0d exp=0", sb.size());
        end
        done = 1'b1;
        summary();
    end
endmodule